// File: doc/BRIEF.md
# Adaptive Harmonic Estimator Channel

This block is one measurement channel of a harmonic analyser built around an adaptive linear neuron. Once per base period the channel takes one signed sample of the measured signal and the 2N sine and cosine basis values of that instant, which a shared phase generator delivers as a time-multiplexed stream. It forms the estimate as a bias weight plus the dot product of the weight vector with the basis vector. It then forms the error between sample and estimate and adapts every weight by the least-mean-square rule. After convergence the weights are the Fourier coefficients of the tracked harmonics, and the bias weight is the mean of the signal.

One signed multiplier serves the whole pass. During the gathering phase it walks the incoming basis words against the stored weights. It is used once more to scale the error by the programmable step, and then walks the stored basis words a second time to adapt the weights. The weights sit in a small register file of 2N+1 entries, and all of them are visible on one flat output port.

A pass runs through five named states. IDLE leaves to GATHER when `start_i` is high, and the sample is captured on that edge. GATHER leaves to RESOLVE on the edge that accepts the 2N-th basis word. RESOLVE always moves to ADAPT after one cycle. ADAPT leaves to DONE after its 2N+1-th slot. DONE always returns to IDLE.

Top module: `hest_channel`

## Requirements
- R1: A synchronous reset clears every weight, `est_o` and `err_o` to zero, and holds `valid_o` low.
- R2: The estimate is computed in a saturating 40-bit accumulator that starts at W0·2^15 and adds Wi·Xi for i = 1..2N. The accumulator is shifted right arithmetically by 15 and saturated to 16 bits. `est_o` changes only on the edge that leaves RESOLVE.
- R3: `err_o` is the captured sample minus the estimate, as a 17-bit signed value.
- R4: The gain is sat_W((step·e) >>> STEP_SH), where `step_i` is an unsigned value read in the RESOLVE cycle. W0 gains the full gain. Weight i (1..2N), which pairs with the i-th accepted basis word of the pass, gains (gain·Xi) >>> 15.
- R5: Every weight saturates at -2^(W_W-1) and 2^(W_W-1)-1 instead of wrapping.
- R6: `valid_o` is high for exactly one cycle, the DONE state. It begins 2N+2 rising edges after the edge that accepted the last basis word, and the estimate, error and weights are final at that point.
- R7: `start_i` is ignored outside IDLE. The captured sample does not change, and no new pass starts.
- R8: In GATHER a basis word is taken only on a cycle with `basis_vld_i` high, and gaps stall the pass. `basis_vld_i` and `basis_i` have no effect in any other state.
- R9: When the gain is zero, which is the case with `step_i` = 0, the adapt pass leaves every weight unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts a pass in IDLE and captures `sample_i` |
| sample_i | input | D_W (16) | Signed Q1.15 measured sample |
| basis_vld_i | input | 1 | Marks a valid basis word in GATHER |
| basis_i | input | D_W (16) | Signed Q1.15 sine or cosine basis value |
| step_i | input | STEP_W (16) | Unsigned step size, read in RESOLVE |
| est_o | output | D_W (16) | Estimate of the latest pass |
| err_o | output | D_W+1 (17) | Estimation error of the latest pass |
| valid_o | output | 1 | One-cycle end-of-pass strobe |
| weights_o | output | (2·N_HARM+1)·W_W (216) | Weight i at bits [i·W_W +: W_W]; weight 0 is the bias |

## Verification
The functions that can coincide are the gathering of a new basis word and a stray `start_i`, and likewise a weight write in ADAPT and a late `start_i`. The bench pulses `start_i` with a different sample on every gather and adapt cycle of one pass. It then requires estimate, error and weights to match a model that uses only the first sample. Idle-time basis strobes and gaps inside GATHER are checked the same way: every clock, `valid_o` is compared against the model's predicted cycle, and at DONE every weight is compared against the model.

// File: rtl/hest_pkg.sv
package hest_pkg;

    // Pass sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATHER,
        ST_RESOLVE,
        ST_ADAPT,
        ST_DONE
    } hest_state_t;

endpackage

// File: rtl/hest_mul.sv
module hest_mul #(
    parameter int A_W = 24,
    parameter int B_W = 17
) (
    input  logic signed [A_W-1:0]     a,
    input  logic signed [B_W-1:0]     b,
    output logic signed [A_W+B_W-1:0] p
);
    // Single shared signed multiplier for every phase of a pass
    assign p = a * b;
endmodule

// File: rtl/hest_wram.sv
module hest_wram #(
    parameter int DEPTH = 9,
    parameter int WIDTH = 24,
    parameter int AW    = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [AW-1:0]           rd_addr,
    output logic signed [WIDTH-1:0] rd_data,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic signed [WIDTH-1:0] wr_data,
    output logic [DEPTH*WIDTH-1:0]  flat_o
);
    logic signed [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign flat_o[g*WIDTH +: WIDTH] = mem[g];
    end
endmodule

// File: rtl/hest_channel.sv
module hest_channel
    import hest_pkg::*;
#(
    parameter int N_HARM  = 4,
    parameter int D_W     = 16,
    parameter int W_W     = 24,
    parameter int ACC_W   = 40,
    parameter int STEP_W  = 16,
    parameter int STEP_SH = 15
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start_i,
    input  logic signed [D_W-1:0]             sample_i,
    input  logic                              basis_vld_i,
    input  logic signed [D_W-1:0]             basis_i,
    input  logic [STEP_W-1:0]                 step_i,
    output logic signed [D_W-1:0]             est_o,
    output logic signed [D_W:0]               err_o,
    output logic                              valid_o,
    output logic [(2*N_HARM+1)*W_W-1:0]       weights_o
);
    localparam int N_W    = 2 * N_HARM + 1;
    localparam int IDX_W  = $clog2(N_W);
    localparam int FRAC   = D_W - 1;
    localparam int E_W    = D_W + 1;
    localparam int P_W    = W_W + E_W;
    localparam int SW     = ((ACC_W > P_W) ? ACC_W : P_W) + 2;
    localparam logic [IDX_W-1:0] LAST_G = IDX_W'(2 * N_HARM - 1);
    localparam logic [IDX_W-1:0] LAST_U = IDX_W'(N_W - 1);
    localparam logic signed [E_W-1:0] ONE = E_W'(1) <<< FRAC;

    function automatic logic signed [W_W-1:0] sat_wt(input logic signed [SW-1:0] v);
        logic signed [SW-1:0] hi, lo;
        hi = (SW'(1) <<< (W_W - 1)) - SW'(1);
        lo = ~hi;
        if (v > hi)      return hi[W_W-1:0];
        else if (v < lo) return lo[W_W-1:0];
        else             return v[W_W-1:0];
    endfunction

    function automatic logic signed [ACC_W-1:0] sat_acc(input logic signed [SW-1:0] v);
        logic signed [SW-1:0] hi, lo;
        hi = (SW'(1) <<< (ACC_W - 1)) - SW'(1);
        lo = ~hi;
        if (v > hi)      return hi[ACC_W-1:0];
        else if (v < lo) return lo[ACC_W-1:0];
        else             return v[ACC_W-1:0];
    endfunction

    function automatic logic signed [D_W-1:0] sat_d(input logic signed [SW-1:0] v);
        logic signed [SW-1:0] hi, lo;
        hi = (SW'(1) <<< (D_W - 1)) - SW'(1);
        lo = ~hi;
        if (v > hi)      return hi[D_W-1:0];
        else if (v < lo) return lo[D_W-1:0];
        else             return v[D_W-1:0];
    endfunction

    hest_state_t st, st_nx;

    logic [IDX_W-1:0]         idx;
    logic signed [ACC_W-1:0]  acc;
    logic signed [D_W-1:0]    samp_q;
    logic signed [W_W-1:0]    gain_q;
    logic signed [D_W-1:0]    est_q;
    logic signed [E_W-1:0]    err_q;
    logic signed [D_W-1:0]    xbuf [N_W];

    logic [IDX_W-1:0]         rd_addr;
    logic signed [W_W-1:0]    w_rd;
    logic signed [W_W-1:0]    w_new;
    logic                     wr_en;
    logic signed [W_W-1:0]    mul_a;
    logic signed [E_W-1:0]    mul_b;
    logic signed [P_W-1:0]    prod;

    logic signed [SW-1:0]     acc_x, prod_x;
    logic signed [ACC_W-1:0]  acc_nx;
    logic signed [D_W-1:0]    est_c;
    logic signed [E_W-1:0]    err_c;
    logic signed [W_W-1:0]    gain_c;

    hest_wram #(.DEPTH(N_W), .WIDTH(W_W), .AW(IDX_W)) i_wram (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (rd_addr),
        .rd_data (w_rd),
        .wr_en   (wr_en),
        .wr_addr (idx),
        .wr_data (w_new),
        .flat_o  (weights_o)
    );

    hest_mul #(.A_W(W_W), .B_W(E_W)) i_mul (
        .a (mul_a),
        .b (mul_b),
        .p (prod)
    );

    // Arithmetic around the shared multiplier
    always_comb begin
        acc_x  = SW'(acc);
        prod_x = SW'(prod);
        acc_nx = sat_acc(acc_x + prod_x);
        est_c  = sat_d(acc_x >>> FRAC);
        err_c  = E_W'(samp_q) - E_W'(est_c);
        gain_c = sat_wt(prod_x >>> STEP_SH);
        w_new  = sat_wt(SW'(w_rd) + (prod_x >>> FRAC));
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (start_i) st_nx = ST_GATHER;
            ST_GATHER:  if (basis_vld_i && idx == LAST_G) st_nx = ST_RESOLVE;
            ST_RESOLVE: st_nx = ST_ADAPT;
            ST_ADAPT:   if (idx == LAST_U) st_nx = ST_DONE;
            ST_DONE:    st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // Outputs and operand selection per state
    always_comb begin
        rd_addr = idx;
        mul_a   = w_rd;
        mul_b   = E_W'(basis_i);
        wr_en   = 1'b0;
        valid_o = 1'b0;
        unique case (st)
            ST_GATHER:  rd_addr = idx + 1'b1;
            ST_RESOLVE: begin
                mul_a = $signed({{(W_W-STEP_W){1'b0}}, step_i});
                mul_b = err_c;
            end
            ST_ADAPT: begin
                mul_a = gain_q;
                mul_b = (idx == '0) ? ONE : E_W'(xbuf[idx]);
                wr_en = 1'b1;
            end
            ST_DONE:    valid_o = 1'b1;
            default: ;
        endcase
    end

    assign est_o = est_q;
    assign err_o = err_q;

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            idx    <= '0;
            acc    <= '0;
            samp_q <= '0;
            gain_q <= '0;
            est_q  <= '0;
            err_q  <= '0;
            for (int i = 0; i < N_W; i++) xbuf[i] <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start_i) begin
                    samp_q <= sample_i;
                    acc    <= ACC_W'(w_rd) <<< FRAC;
                    idx    <= '0;
                end
                ST_GATHER: if (basis_vld_i) begin
                    acc                <= acc_nx;
                    xbuf[idx + 1'b1]   <= basis_i;
                    idx                <= (idx == LAST_G) ? '0 : idx + 1'b1;
                end
                ST_RESOLVE: begin
                    est_q  <= est_c;
                    err_q  <= err_c;
                    gain_q <= gain_c;
                end
                ST_ADAPT: idx <= (idx == LAST_U) ? '0 : idx + 1'b1;
                default: ;
            endcase
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && start_i) |=> $stable(samp_q));

    // R8
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GATHER && !basis_vld_i) |=> ($stable(idx) && $stable(acc)));

    // R2
    est_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st != ST_RESOLVE) |=> $stable(est_o));

    // R4
    adapt_walk_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ADAPT && idx != LAST_U) |=> (st == ST_ADAPT && idx == $past(idx) + 1'b1));

    // R9
    zero_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ADAPT && gain_q == '0) |=> $stable(weights_o));
endmodule

// File: tb/test_hest_channel.sv
module test_hest_channel;
    localparam int CLK_P   = 10;
    localparam int NH      = 4;
    localparam int NB      = 2 * NH;
    localparam int NW      = NB + 1;
    localparam int DW      = 16;
    localparam int WW      = 17;
    localparam int AW      = 40;
    localparam int SH      = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic signed [DW-1:0] sample_i = '0;
    logic basis_vld_i = 1'b0;
    logic signed [DW-1:0] basis_i = '0;
    logic [15:0] step_i = '0;
    logic signed [DW-1:0] est_o;
    logic signed [DW:0] err_o;
    logic valid_o;
    logic [NW*WW-1:0] weights_o;

    hest_channel #(.N_HARM(NH), .D_W(DW), .W_W(WW), .ACC_W(AW), .STEP_W(16), .STEP_SH(SH))
    i_hest_channel (
        .clk(clk), .rst(rst), .start_i(start_i), .sample_i(sample_i),
        .basis_vld_i(basis_vld_i), .basis_i(basis_i), .step_i(step_i),
        .est_o(est_o), .err_o(err_o), .valid_o(valid_o), .weights_o(weights_o)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    string scen = "reset";
    bit mon_on = 1'b0;
    bit chk_out = 1'b0;
    bit exp_valid = 1'b0;
    longint exp_est = 0;
    longint exp_err = 0;
    longint mw [NW];
    logic signed [DW-1:0] bx [NB];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (%s)", req, act, exp, scen);
        end
    endtask

    function automatic longint satl(input longint v, input int bits);
        longint hi, lo;
        hi = (64'sd1 <<< (bits - 1)) - 1;
        lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint wport(input int i);
        logic signed [WW-1:0] w;
        w = weights_o[i*WW +: WW];
        return longint'(w);
    endfunction

    // Behavioural model of one pass (R2, R3, R4, R5)
    task automatic model_pass(input longint s, input longint stp);
        longint acc, est, e, g;
        acc = mw[0] * 32768;
        for (int i = 0; i < NB; i++) acc = satl(acc + mw[i+1] * longint'(bx[i]), AW);
        est = satl(acc >>> 15, DW);
        e   = s - est;
        g   = satl((stp * e) >>> SH, WW);
        mw[0] = satl(mw[0] + g, WW);
        for (int i = 0; i < NB; i++) mw[i+1] = satl(mw[i+1] + ((g * longint'(bx[i])) >>> 15), WW);
        exp_est = est;
        exp_err = e;
    endtask

    // Compared on every clock
    always begin
        @(negedge clk);
        #2;
        if (mon_on) begin
            chk(valid_o == exp_valid, "R6 valid", longint'(valid_o), longint'(exp_valid));
            if (chk_out) begin
                chk(longint'(est_o) == exp_est, "R2 estimate", longint'(est_o), exp_est);
                chk(longint'(err_o) == exp_err, "R3 error", longint'(err_o), exp_err);
                for (int i = 0; i < NW; i++)
                    chk(wport(i) == mw[i], "R4 weight", wport(i), mw[i]);
            end
        end
    end

    task automatic run_pass(input int s, input int stp, input bit gaps, input bit poke);
        @(negedge clk);
        chk_out = 1'b0;
        start_i = 1'b1; sample_i = DW'(s); step_i = 16'(stp); basis_vld_i = 1'b0;
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            start_i = poke; sample_i = poke ? DW'(-s - 7) : DW'(s);
            if (gaps && (i % 2 == 1)) begin
                basis_vld_i = 1'b0; basis_i = 16'sh7abc;
                @(negedge clk);
            end
            basis_vld_i = 1'b1; basis_i = bx[i];
        end
        @(negedge clk);
        basis_vld_i = 1'b0;
        repeat (NB + 1) @(negedge clk);
        @(negedge clk);
        start_i = 1'b0; sample_i = DW'(s);
        model_pass(longint'(s), longint'(stp));
        exp_valid = 1'b1;
        chk_out = 1'b1;
        @(negedge clk);
        exp_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mon_on = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NW; i++) mw[i] = 0;
        exp_est = 0; exp_err = 0; exp_valid = 1'b0; chk_out = 1'b1;
        #2;
        // R1: reset state
        chk(valid_o == 1'b0, "R1 valid", longint'(valid_o), 0);
        chk(est_o == '0, "R1 estimate", longint'(est_o), 0);
        chk(err_o == '0, "R1 error", longint'(err_o), 0);
        for (int i = 0; i < NW; i++) chk(wport(i) == 0, "R1 weight", wport(i), 0);
        mon_on = 1'b1;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint first_err, last_err;
        do_reset();

        scen = "R2 R3 R4 basic";
        for (int i = 0; i < NB; i++) bx[i] = DW'((i % 2 == 0) ? 12000 - i * 900 : -9000 + i * 700);
        run_pass(20000, 8192, 1'b0, 1'b0);
        run_pass(-15000, 8192, 1'b0, 1'b0);
        for (int i = 0; i < NB; i++) bx[i] = DW'((i < NH) ? 32767 - i * 5000 : -32768 + i * 3000);
        run_pass(32767, 16000, 1'b0, 1'b0);
        run_pass(-32768, 65535, 1'b0, 1'b0);

        scen = "R8 idle strobes and gather gaps";
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            basis_vld_i = 1'b1; basis_i = DW'(k * 3000 - 7000);
        end
        @(negedge clk); basis_vld_i = 1'b0;
        run_pass(5000, 12000, 1'b1, 1'b0);

        scen = "R7 start while busy";
        run_pass(-8000, 12000, 1'b1, 1'b1);

        scen = "R9 zero step";
        run_pass(25000, 0, 1'b0, 1'b1);

        scen = "R4 convergence";
        do_reset();
        for (int i = 0; i < NB; i++) bx[i] = DW'((i % 2 == 0) ? 4096 : -4096);
        run_pass(10000, 8192, 1'b0, 1'b0);
        first_err = exp_err;
        for (int k = 0; k < 20; k++) run_pass(10000, 8192, 1'b0, 1'b0);
        last_err = (exp_err < 0) ? -exp_err : exp_err;
        chk(last_err * 4 < first_err, "R4 error shrinks", last_err, first_err / 4);

        scen = "R5 saturation";
        do_reset();
        for (int i = 0; i < NB; i++) bx[i] = -16'sd32768;
        run_pass(32767, 65535, 1'b0, 1'b0);
        for (int i = 0; i < NB; i++) bx[i] = 16'sd32767;
        run_pass(32767, 65535, 1'b0, 1'b0);
        @(negedge clk); #2;
        chk(wport(0) == (64'sd1 <<< (WW - 1)) - 1, "R5 bias clipped at max", wport(0),
            (64'sd1 <<< (WW - 1)) - 1);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule